// File: doc/BRIEF.md
# Edge-Triggered Interrupt Line Controller

This block watches a group of asynchronous input lines and records, per line, that a selected edge has occurred. Software picks the edges to watch through two enable registers on a simple single-cycle register bus. One register enables rising-edge capture and the other enables falling-edge capture. A line may have both enabled, one, or neither. A captured edge sets a sticky pending bit. Software reads the pending bits and clears them by writing ones.

Each line first passes through a two-flop synchroniser. An edge is the difference between the synchronised level and the same level one clock earlier. A steady level therefore never produces more than one event. The interrupt output is a registered OR of all pending bits. The line set has one hole: line 17 has no storage in any register and can never become pending. A rising edge that is seen in the same cycle as a bus write to the rising-enable register is dropped. A falling edge in that cycle is still captured.

Top module: `edge_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, both enable registers and the pending register read zero and `irq_o` is low.
- R2: The rising-enable register is at offset 0x08. A write stores `wdata_i & 0x007D_FFFF`, and a read returns the stored value. Bit 17 and bits 31:23 always read zero.
- R3: The falling-enable register is at offset 0x0C and has the same masking and read-back as R2.
- R4: When rising capture is enabled for a line (bit n at 0x08 = 1), a 0→1 change on `line_i[n]` sets pending bit n. The bit reads back set after the third rising clock edge that follows the change, counting the edge that first samples the new level.
- R5: When falling capture is enabled (bit n at 0x0C = 1), a 1→0 change sets pending bit n with the same latency as R4. With both enables set, each edge sets the bit on its own.
- R6: A line held at a constant level, or an edge whose enable bit is 0, never sets its pending bit.
- R7: A rising edge detected in the cycle where the bus writes offset 0x08 does not set its pending bit. A falling edge detected in that same cycle is still captured.
- R8: The pending register is at offset 0x14. Writing 1 to bit n clears it, and writing 0 leaves it unchanged. If a clear and a new edge hit the same bit in the same cycle, the bit stays set.
- R9: `irq_o` is high one cycle after any pending bit is set, and low one cycle after all pending bits are zero.
- R10: A read from any offset other than 0x08, 0x0C or 0x14 returns zero. A write to such an offset changes no register.
- R11: Line 17 never sets pending bit 17, and that bit always reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_i | input | 23 | Asynchronous input lines |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| wen_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Registered OR of the pending bits |

## Verification
Register writes take effect at the clock edge that ends the write cycle, and reads are combinational. A line change appears in the pending read-back after the third rising clock edge, and `irq_o` follows one edge later. The bench keeps a cycle model with a three-deep history of the driven line levels. Every cycle, at the falling clock edge and before new stimulus is applied, it compares the pending read-back and `irq_o` with that model. The latency, the dropped rising edge during a write to 0x08, and the set-wins case use directed sequences that place each edge in exactly the detection cycle they need.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int unsigned OFS_RISE = 32'h08;
  localparam int unsigned OFS_FALL = 32'h0C;
  localparam int unsigned OFS_PEND = 32'h14;
endpackage

// File: rtl/eic_line_sync.sv
module eic_line_sync #(
  parameter int unsigned N = 23
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic meta_q, sync_q, prev_q;
    logic meta_d, sync_d, prev_d;

    always_comb begin
      meta_d = line_i[g];
      sync_d = meta_q;
      prev_d = sync_q;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= meta_d;
        sync_q <= sync_d;
        prev_q <= prev_d;
      end
    end

    assign rise_o[g] = sync_q & ~prev_q;
    assign fall_o[g] = ~sync_q & prev_q;

    // R6: a level cannot yield two rising events in a row
    a_r6_single_rise: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      rise_o[g] |=> !rise_o[g]);
    a_r6_single_fall: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      fall_o[g] |=> !fall_o[g]);
  end
endmodule

// File: rtl/eic_trig_regs.sv
module eic_trig_regs
  import eic_pkg::*;
#(
  parameter int unsigned N      = 23,
  parameter logic [N-1:0] MASK  = 23'h7D_FFFF,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wen_i,
  input  logic [N-1:0]      pend_i,
  output logic [N-1:0]      rise_en_o,
  output logic [N-1:0]      fall_en_o,
  output logic              wr_rise_o,
  output logic [N-1:0]      clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel_rise, sel_fall, sel_pend, sel_any;
  logic [N-1:0] rise_q, rise_d, fall_q, fall_d, wmask;
  logic rise_ce, fall_ce;

  assign sel_rise = (addr_i == ADDR_W'(OFS_RISE));
  assign sel_fall = (addr_i == ADDR_W'(OFS_FALL));
  assign sel_pend = (addr_i == ADDR_W'(OFS_PEND));
  assign sel_any  = sel_rise | sel_fall | sel_pend;
  assign wmask    = wdata_i[N-1:0] & MASK;

  always_comb begin
    rise_ce = wen_i & sel_rise;
    fall_ce = wen_i & sel_fall;
    rise_d  = rise_ce ? wmask : rise_q;
    fall_d  = fall_ce ? wmask : fall_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign wr_rise_o = wen_i & sel_rise;
  assign clr_o     = (wen_i && sel_pend) ? wmask : '0;

  always_comb begin
    rdata_o = '0;
    if (sel_rise)      rdata_o[N-1:0] = rise_q;
    else if (sel_fall) rdata_o[N-1:0] = fall_q;
    else if (sel_pend) rdata_o[N-1:0] = pend_i;
  end

  // R2: a write to the rising-enable offset lands masked next cycle
  a_r2_rise_write: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wen_i && sel_rise) |=> (rise_q == $past(wdata_i[N-1:0] & MASK)));
  // R3
  a_r3_fall_write: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wen_i && sel_fall) |=> (fall_q == $past(wdata_i[N-1:0] & MASK)));
  // R10: unmapped writes leave configuration untouched
  a_r10_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wen_i && !sel_any) |=> ($stable(rise_q) && $stable(fall_q)));
endmodule

// File: rtl/eic_pending.sv
module eic_pending #(
  parameter int unsigned N     = 23,
  parameter logic [N-1:0] MASK = 23'h7D_FFFF
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q, pend_d;
  logic irq_q, irq_d;

  always_comb begin
    pend_d = ((pend_q & ~clr_i) | set_i) & MASK;
    irq_d  = |pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R8: a new event is never lost, even against a clear
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((set_i & MASK) != '0) |=> ((pend_q & $past(set_i & MASK)) == $past(set_i & MASK)));
  // R8: a clear with no competing event empties the bit
  a_r8_w1c: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((clr_i & ~set_i) != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int unsigned N          = 23,
  parameter logic [N-1:0] LINE_MASK = 23'h7D_FFFF,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [N-1:0]      line_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wen_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [N-1:0] rise_ev, fall_ev, rise_en, fall_en, clr, pend, set;
  logic [N-1:0] rise_hit, fall_hit;
  logic         wr_rise;

  eic_line_sync #(.N(N)) u_sync (
    .clk_i(clk_i), .rst_n_i(rst_n), .line_i(line_i),
    .rise_o(rise_ev), .fall_o(fall_ev)
  );

  eic_trig_regs #(.N(N), .MASK(LINE_MASK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_n_i(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .wen_i(wen_i), .pend_i(pend), .rise_en_o(rise_en), .fall_en_o(fall_en),
    .wr_rise_o(wr_rise), .clr_o(clr), .rdata_o(rdata_o)
  );

  always_comb begin
    rise_hit = wr_rise ? '0 : (rise_ev & rise_en);
    fall_hit = fall_ev & fall_en;
    set      = rise_hit | fall_hit;
  end

  eic_pending #(.N(N), .MASK(LINE_MASK)) u_pend (
    .clk_i(clk_i), .rst_n_i(rst_n), .set_i(set), .clr_i(clr),
    .pend_o(pend), .irq_o(irq_o)
  );

  // R7: during a rising-enable write only falling events may add pending bits
  a_r7_rise_write_drop: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_rise |=> (((pend & ~$past(pend)) & ~$past(fall_hit)) == '0));
  // R9
  a_r9_irq_high: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pend != '0) |=> irq_o);
  a_r9_irq_low: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pend == '0) |=> !irq_o);
endmodule

// File: tb/tb_edge_irq_ctrl.sv
module tb_edge_irq_ctrl;
  localparam logic [22:0] MSK = 23'h7D_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [22:0] line;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic        wen;
  logic [31:0] rdata;
  logic        irq;

  always #10 clk = ~clk;

  edge_irq_ctrl dut (
    .clk_i(clk), .rst_n_i(rst_n), .line_i(line), .addr_i(addr),
    .wdata_i(wdata), .wen_i(wen), .rdata_o(rdata), .irq_o(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [22:0] m_rise, m_fall, m_pend, h1, h2, h3;
  logic        m_irq;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    wen = 1'b0; addr = a; #1; v = rdata;
  endtask

  function automatic logic [22:0] next_set(input logic [22:0] r_en, input logic [22:0] f_en,
                                           input logic [22:0] a2, input logic [22:0] a3,
                                           input bit wr_r);
    logic [22:0] re, fe;
    re = a2 & ~a3;
    fe = ~a2 & a3;
    return ((wr_r ? 23'd0 : (re & r_en)) | (fe & f_en)) & MSK;
  endfunction

  // one clock cycle: check model, drive, advance model; called at negedge
  task automatic cycle(input logic [22:0] ln, input bit w, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] v;
    logic [22:0] s, c;
    bit wr_r;
    rd(8'h14, v);
    chk(v == {9'd0, m_pend}, "R4 R5 R7 R8 pending model", v, {9'd0, m_pend});
    chk(irq == m_irq, "R9 irq model", {31'd0, irq}, {31'd0, m_irq});
    line = ln; wen = w; addr = a; wdata = d;
    wr_r = w && (a == 8'h08);
    s = next_set(m_rise, m_fall, h2, h3, wr_r);
    c = (w && a == 8'h14) ? (d[22:0] & MSK) : 23'd0;
    m_irq  = |m_pend;
    m_pend = (m_pend & ~c) | s;
    if (w && a == 8'h08) m_rise = d[22:0] & MSK;
    if (w && a == 8'h0C) m_fall = d[22:0] & MSK;
    h3 = h2; h2 = h1; h1 = ln;
    @(posedge clk);
    @(negedge clk);
    wen = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [22:0] cur;
    void'($urandom(32'd20240611));
    m_rise = '0; m_fall = '0; m_pend = '0; m_irq = 1'b0;
    h1 = '0; h2 = '0; h3 = '0; cur = '0;
    rst_n = 1'b0; line = '0; addr = '0; wdata = '0; wen = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    rd(8'h08, v); chk(v == 0, "R1 rise in reset", v, 0);
    chk(irq == 1'b0, "R1 irq in reset", {31'd0, irq}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h08, v); chk(v == 0, "R1 rise after reset", v, 0);
    rd(8'h0C, v); chk(v == 0, "R1 fall after reset", v, 0);
    rd(8'h14, v); chk(v == 0, "R1 pend after reset", v, 0);
    chk(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 0);

    // R2 / R3 masking
    cycle(cur, 1'b1, 8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk(v == 32'h007D_FFFF, "R2 rise mask", v, 32'h007D_FFFF);
    cycle(cur, 1'b1, 8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk(v == 32'h007D_FFFF, "R3 fall mask", v, 32'h007D_FFFF);

    // R10 unmapped
    cycle(cur, 1'b1, 8'h10, 32'h0000_0000);
    rd(8'h10, v); chk(v == 0, "R10 unmapped read", v, 0);
    rd(8'h08, v); chk(v == 32'h007D_FFFF, "R10 rise kept", v, 32'h007D_FFFF);
    rd(8'h0C, v); chk(v == 32'h007D_FFFF, "R10 fall kept", v, 32'h007D_FFFF);

    // config: line0 rise only, line1 fall only, line2 both, line3 rise only
    cycle(cur, 1'b1, 8'h08, 32'h0000_000D);
    cycle(cur, 1'b1, 8'h0C, 32'h0000_0006);

    // R4 latency on line 0
    cur[0] = 1'b1; cycle(cur, 1'b0, 8'h00, 0);
    rd(8'h14, v); chk(v[0] == 1'b0, "R4 not after 1 edge", v, 0);
    cycle(cur, 1'b0, 8'h00, 0);
    rd(8'h14, v); chk(v[0] == 1'b0, "R4 not after 2 edges", v, 0);
    cycle(cur, 1'b0, 8'h00, 0);
    rd(8'h14, v); chk(v[0] == 1'b1, "R4 set after 3 edges", v, 1);
    cycle(cur, 1'b0, 8'h00, 0);
    chk(irq == 1'b1, "R9 irq raised", {31'd0, irq}, 1);

    // R6 level hold and disabled edge: line 0 falls (no fall enable), line1 rises (disabled)
    cycle(cur, 1'b1, 8'h14, 32'h1);
    cur[0] = 1'b0; cur[1] = 1'b1;
    cycle(cur, 1'b0, 0, 0);
    repeat (4) cycle(cur, 1'b0, 0, 0);
    rd(8'h14, v); chk(v == 0, "R6 disabled edges and held level", v, 0);
    chk(irq == 1'b0, "R9 irq dropped", {31'd0, irq}, 0);

    // R5 both edges on line 2
    cur[2] = 1'b1; cycle(cur, 1'b0, 0, 0);
    repeat (3) cycle(cur, 1'b0, 0, 0);
    rd(8'h14, v); chk(v[2] == 1'b1, "R5 rise on both-line", v, 4);
    cycle(cur, 1'b1, 8'h14, 32'h4);
    cur[2] = 1'b0; cycle(cur, 1'b0, 0, 0);
    repeat (3) cycle(cur, 1'b0, 0, 0);
    rd(8'h14, v); chk(v[2] == 1'b1, "R5 fall on both-line", v, 4);
    cycle(cur, 1'b1, 8'h14, 32'h4);

    // R7: line3 rises and line1 falls, detection coincides with rise-register write
    cur[3] = 1'b1; cur[1] = 1'b0; cycle(cur, 1'b0, 0, 0);
    cycle(cur, 1'b0, 0, 0);
    cycle(cur, 1'b1, 8'h08, 32'h0000_000D);
    rd(8'h14, v); chk(v[3] == 1'b0, "R7 rising edge dropped", v, 0);
    chk(v[1] == 1'b1, "R7 falling edge kept", v, 2);
    repeat (2) cycle(cur, 1'b0, 0, 0);
    cycle(cur, 1'b1, 8'h14, 32'h2);

    // R8 set wins: bit0 pending, clear it in the cycle its next rise is detected
    cur[0] = 1'b1; cycle(cur, 1'b0, 0, 0);
    repeat (3) cycle(cur, 1'b0, 0, 0);
    cur[0] = 1'b0; cycle(cur, 1'b0, 0, 0);
    repeat (2) cycle(cur, 1'b0, 0, 0);
    cur[0] = 1'b1; cycle(cur, 1'b0, 0, 0);
    cycle(cur, 1'b0, 0, 0);
    cycle(cur, 1'b1, 8'h14, 32'h1);
    rd(8'h14, v); chk(v[0] == 1'b1, "R8 set beats clear", v, 1);
    cycle(cur, 1'b1, 8'h14, 32'h1);
    rd(8'h14, v); chk(v[0] == 1'b0, "R8 w1c clears", v, 0);

    // R11 line 17 with everything enabled
    cycle(cur, 1'b1, 8'h08, 32'hFFFF_FFFF);
    cycle(cur, 1'b1, 8'h0C, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) begin
      cur[17] = ~cur[17];
      cycle(cur, 1'b0, 0, 0);
      cycle(cur, 1'b0, 0, 0);
    end
    repeat (3) cycle(cur, 1'b0, 0, 0);
    rd(8'h14, v); chk(v[17] == 1'b0, "R11 hole never pends", v, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [22:0] tog;
      int r;
      tog = 23'($urandom & $urandom & $urandom);
      cur = cur ^ tog;
      r = int'($urandom % 16);
      case (r)
        0: cycle(cur, 1'b1, 8'h08, $urandom);
        1: cycle(cur, 1'b1, 8'h0C, $urandom);
        2, 3: cycle(cur, 1'b1, 8'h14, $urandom);
        4: cycle(cur, 1'b1, 8'($urandom), $urandom);
        default: cycle(cur, 1'b0, 8'h00, 0);
      endcase
    end
    rd(8'h20, v); chk(v == 0, "R10 unmapped read after random", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule